// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This block owns the modem side of a serial port. It keeps a small control register whose bits drive four outward handshake pins (request-to-send, terminal-ready and two general-purpose outputs) and select a self-test loop. It also watches four inward handshake lines: clear-to-send, set-ready, carrier detect and ring indicator. It presents their current levels together with sticky change flags as one status byte.

The inward lines are asynchronous. They pass through a configurable synchronizer chain before they are compared with the last captured levels. When the loop bit is set, the block stops looking at the pins. It feeds its own control bits back into the status path with a fixed crossing, and it parks the outward pins low so that the far end sees an idle interface. Any set change flag raises a single pending output for a separate interrupt unit. Reading the status byte clears the change flags.

Top module: `mdm_ctl_stat`

## Requirements
- R1: After reset the control readback is 0x08, only `out2_o` is high among the four outward pins, the status byte reads 0xB0 and `delta_pending` is low.
- R2: A control write stores `ctrl_wdata[4:0]`. Bits 7..5 of the readback are always zero. Bit 0 is terminal-ready, bit 1 request-to-send, bit 2 general output 1, bit 3 general output 2 and bit 4 the loop select.
- R3: With the loop bit clear, `dtr_o`, `rts_o`, `out1_o` and `out2_o` follow control bits 0, 1, 2 and 3.
- R4: Status bits 7, 6, 5 and 4 are carrier detect, ring indicator, set-ready and clear-to-send. Outside loop mode they show an input change exactly SYNC_STAGES+1 clock edges after the pin moves.
- R5: Status bits 3, 1 and 0 (change flags of carrier detect, set-ready and clear-to-send) are set by any change of the captured level of their line, in either direction.
- R6: Status bit 2 is set only when the captured ring indicator falls from 1 to 0. A rising ring indicator leaves it unchanged.
- R7: Change flags stay set until a status read. The read clears them at the following edge, but a change captured on that same edge is kept.
- R8: `delta_pending` is high exactly when any of status bits 3..0 is set.
- R9: With the loop bit set, the status upper nibble shows general output 2 as carrier detect, general output 1 as ring indicator, terminal-ready as set-ready and request-to-send as clear-to-send, one edge after the control register changes. The external modem inputs have no effect.
- R10: With the loop bit set, all four outward pins are driven low, whatever the other control bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_rdata | output | 8 | Control register readback |
| stat_rd | input | 1 | Status read strobe; clears change flags |
| stat_rdata | output | 8 | Status byte: line levels and change flags |
| cts_i | input | 1 | Clear-to-send input (asynchronous) |
| dsr_i | input | 1 | Set-ready input (asynchronous) |
| dcd_i | input | 1 | Carrier detect input (asynchronous) |
| ri_i | input | 1 | Ring indicator input (asynchronous) |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Terminal-ready output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| delta_pending | output | 1 | Any change flag set |

## Verification
The bench builds the block with SYNC_STAGES = 2. That gives a three-edge input latency, short enough to sweep every ordered pair of the 16 input-line states and compare the flags against arithmetic expectations. All 32 storable control values are written and their pin images checked. All 16 loop-mode control patterns are walked in sequence, which covers every crossing of control bits onto status bits and the flags those crossings produce. Directed cases pin down the exact latency edge, flags that remain set after a line returns to its old level, and a read that lands on the same edge as a fresh change.

// File: rtl/mdm_pkg.sv
`timescale 1ns/1ps
package mdm_pkg;
   // Captured line levels; packed order gives status bits 7..4 and the
   // matching change-flag bits 3..0.
   typedef struct packed {
      logic dcd;
      logic ri;
      logic dsr;
      logic cts;
   } mdm_lines_t;

   localparam int LINES_W  = 4;
   localparam int CTL_W    = 5;
   localparam int CTL_DTR  = 0;
   localparam int CTL_RTS  = 1;
   localparam int CTL_OUT1 = 2;
   localparam int CTL_OUT2 = 3;
   localparam int CTL_LOOP = 4;
   localparam int FLG_RI   = 2;

   localparam logic [CTL_W-1:0] CTL_RST   = 5'b0_1000;
   localparam mdm_lines_t       LINES_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
endpackage

// File: rtl/mdm_sync.sv
`timescale 1ns/1ps
module mdm_sync #(
   parameter int               STAGES  = 2,
   parameter int               WIDTH   = 4,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("mdm_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("mdm_sync: WIDTH must be positive");
      end
   endgenerate

   localparam int TOP = STAGES - 1;

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[TOP-1:0], d_i};
   end

   assign q_o = chain_q[TOP];
endmodule

// File: rtl/mdm_ctrl_reg.sv
`timescale 1ns/1ps
module mdm_ctrl_reg
   import mdm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [7:0]       wdata_i,
   output logic [CTL_W-1:0] ctrl_o,
   output logic [3:0]       pins_o
);
   logic [CTL_W-1:0] ctrl_q;
   logic             unused_hi_bits;

   assign unused_hi_bits = ^wdata_i[7:CTL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctrl_q <= CTL_RST;
      else if (wr_i) ctrl_q <= wdata_i[CTL_W-1:0];
   end

   // Pins follow bits 3..0 unless the loop bit parks them low.
   generate
      for (genvar p = 0; p < 4; p++) begin : g_pin
         assign pins_o[p] = ctrl_q[p] & ~ctrl_q[CTL_LOOP];
      end
   endgenerate

   assign ctrl_o = ctrl_q;

   a_r10_pins_parked: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[CTL_LOOP] |-> (pins_o == 4'b0000));
endmodule

// File: rtl/mdm_status.sv
`timescale 1ns/1ps
module mdm_status
   import mdm_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_i,
   input  mdm_lines_t   lines_i,
   output logic [7:0]   rdata_o,
   output logic         pending_o
);
   mdm_lines_t         lines_q;
   logic [LINES_W-1:0] flag_q;
   logic [LINES_W-1:0] chg;
   logic [LINES_W-1:0] flag_d;

   always_comb begin
      chg         = lines_i ^ lines_q;
      chg[FLG_RI] = lines_q.ri & ~lines_i.ri;   // trailing edge only
      flag_d      = (rd_i ? '0 : flag_q) | chg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lines_q <= LINES_RST;
         flag_q  <= '0;
      end else begin
         lines_q <= lines_i;
         flag_q  <= flag_d;
      end
   end

   assign rdata_o   = {lines_q, flag_q};
   assign pending_o = |flag_q;

   a_r5_cts_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (lines_i.cts != lines_q.cts) |=> rdata_o[0]);

   a_r6_ri_rise_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lines_q.ri) && !$past(flag_q[FLG_RI])) |-> !rdata_o[FLG_RI]);

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_i && flag_q[1]) |=> rdata_o[1]);

   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && (lines_i == lines_q)) |=> !pending_o);
endmodule

// File: rtl/mdm_ctl_stat.sv
`timescale 1ns/1ps
module mdm_ctl_stat
   import mdm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_wr,
   input  logic [7:0] ctrl_wdata,
   output logic [7:0] ctrl_rdata,
   input  logic       stat_rd,
   output logic [7:0] stat_rdata,
   input  logic       cts_i,
   input  logic       dsr_i,
   input  logic       dcd_i,
   input  logic       ri_i,
   output logic       rts_o,
   output logic       dtr_o,
   output logic       out1_o,
   output logic       out2_o,
   output logic       delta_pending
);
   logic [CTL_W-1:0]   ctrl_q;
   logic [3:0]         pins;
   logic [LINES_W-1:0] ext_sync;
   mdm_lines_t         lines_sel;

   mdm_ctrl_reg u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (ctrl_wr),
      .wdata_i (ctrl_wdata),
      .ctrl_o  (ctrl_q),
      .pins_o  (pins)
   );

   mdm_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (LINES_W),
      .RST_VAL (LINES_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({dcd_i, ri_i, dsr_i, cts_i}),
      .q_o   (ext_sync)
   );

   always_comb begin
      if (ctrl_q[CTL_LOOP]) begin
         lines_sel.dcd = ctrl_q[CTL_OUT2];
         lines_sel.ri  = ctrl_q[CTL_OUT1];
         lines_sel.dsr = ctrl_q[CTL_DTR];
         lines_sel.cts = ctrl_q[CTL_RTS];
      end else begin
         lines_sel = mdm_lines_t'(ext_sync);
      end
   end

   mdm_status u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_i      (stat_rd),
      .lines_i   (lines_sel),
      .rdata_o   (stat_rdata),
      .pending_o (delta_pending)
   );

   assign ctrl_rdata = {{(8-CTL_W){1'b0}}, ctrl_q};
   assign dtr_o  = pins[CTL_DTR];
   assign rts_o  = pins[CTL_RTS];
   assign out1_o = pins[CTL_OUT1];
   assign out2_o = pins[CTL_OUT2];

   a_r9_loop_crossing: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_q[CTL_LOOP]) |->
         (stat_rdata[4] == $past(ctrl_q[CTL_RTS])) && (stat_rdata[5] == $past(ctrl_q[CTL_DTR])));
endmodule

// File: tb/mdm_ctl_stat_tb.sv
`timescale 1ns/1ps
module mdm_ctl_stat_tb;
   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctrl_wr = 1'b0;
   logic [7:0] ctrl_wdata = 8'h00;
   logic       stat_rd = 1'b0;
   logic [3:0] ext = 4'b1011;          // {dcd, ri, dsr, cts}
   logic [7:0] ctrl_rdata, stat_rdata;
   logic       rts_o, dtr_o, out1_o, out2_o, delta_pending;
   int         errors = 0;
   int         checks = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   mdm_ctl_stat #(.SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .ctrl_rdata(ctrl_rdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
      .cts_i(ext[0]), .dsr_i(ext[1]), .dcd_i(ext[3]), .ri_i(ext[2]),
      .rts_o(rts_o), .dtr_o(dtr_o), .out1_o(out1_o), .out2_o(out2_o),
      .delta_pending(delta_pending)
   );

   function automatic logic [3:0] pins_now();
      return {out2_o, out1_o, rts_o, dtr_o};
   endfunction

   function automatic logic [3:0] exp_flags(input logic [3:0] a, input logic [3:0] b);
      return ((a ^ b) & 4'b1011) | ((a & ~b) & 4'b0100);
   endfunction

   function automatic logic [3:0] loop_map(input logic [3:0] c);
      return {c[3], c[2], c[0], c[1]};
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic nclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd_clear();
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      ctrl_wr    = 1'b1;
      ctrl_wdata = v;
      @(negedge clk);
      ctrl_wr    = 1'b0;
   endtask

   initial begin
      #1600000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [3:0] prev;
      nclk(3);
      // R1 reset state
      check("R1 ctrl reset", ctrl_rdata, 8'h08);
      check("R1 pins reset", {4'h0, pins_now()}, 8'h08);
      check("R1 status reset", stat_rdata, 8'hB0);
      check("R1 pending reset", {7'b0, delta_pending}, 8'h00);
      rst_n = 1'b1;
      nclk(LAT + 2);
      check("R1 status after release", stat_rdata, 8'hB0);

      // R2 R3 R10 control sweep
      for (int v = 0; v < 32; v++) begin
         logic [4:0] c;
         c = v[4:0];
         wr_ctrl({c[2:0] ^ 3'b101, c});
         check("R2 readback", ctrl_rdata, {3'b000, c});
         if (c[4]) check("R10 pins parked", {4'h0, pins_now()}, 8'h00);
         else      check("R3 pins follow", {4'h0, pins_now()}, {4'h0, c[3:0]});
      end
      wr_ctrl(8'h08);
      nclk(LAT + 2);
      rd_clear();
      check("R7 cleared", stat_rdata, 8'hB0);

      // R4 exact latency
      ext = 4'b0011;
      nclk(LAT - 1);
      check("R4 before latency", {stat_rdata[7:4], 4'h0}, 8'hB0);
      nclk(1);
      check("R4 at latency", {stat_rdata[7:4], 4'h0}, 8'h30);
      ext = 4'b1011;
      nclk(LAT + 1);
      rd_clear();

      // R5 R6 R8 sweep of all ordered line-state pairs
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            logic [3:0] fa, fb;
            fa = a[3:0];
            fb = b[3:0];
            ext = fa;
            nclk(LAT + 1);
            rd_clear();
            check("R7 clear before pair", stat_rdata, {fa, 4'h0});
            ext = fb;
            nclk(LAT + 1);
            check("R4 R5 R6 pair", stat_rdata, {fb, exp_flags(fa, fb)});
            check("R8 pending", {7'b0, delta_pending}, {7'b0, |exp_flags(fa, fb)});
         end
      end
      ext = 4'b1011;
      nclk(LAT + 1);
      rd_clear();

      // R7 stickiness and read/change collision
      ext = 4'b1010;
      nclk(LAT + 1);
      ext = 4'b1011;
      nclk(LAT + 1);
      check("R7 sticky after restore", stat_rdata, 8'hB1);
      nclk(5);
      check("R7 still sticky", stat_rdata, 8'hB1);
      rd_clear();
      check("R7 read clears", stat_rdata, 8'hB0);
      ext = 4'b1001;
      nclk(SYNC);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
      check("R7 change on read edge kept", stat_rdata, 8'h92);
      ext = 4'b1011;
      nclk(LAT + 1);
      rd_clear();
      check("R7 clean", stat_rdata, 8'hB0);

      // R9 R10 loop-mode sweep with external inputs toggling
      prev = 4'b1011;
      for (int v = 0; v < 16; v++) begin
         logic [3:0] c;
         c = v[3:0];
         ext = ~ext ^ c;
         wr_ctrl({4'b0001, c});
         nclk(1);
         check("R9 loop status", stat_rdata, {loop_map(c), exp_flags(prev, loop_map(c))});
         check("R10 loop pins low", {4'h0, pins_now()}, 8'h00);
         prev = loop_map(c);
         rd_clear();
      end
      ext = 4'b0100;
      nclk(LAT + 2);
      check("R9 inputs ignored", stat_rdata, {prev, 4'h0});
      wr_ctrl(8'h08);
      ext = 4'b1011;
      nclk(LAT + 1);
      rd_clear();
      check("R9 loop exit", stat_rdata, 8'hB0);
      check("R3 pins after exit", {4'h0, pins_now()}, 8'h08);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule